// File: doc/BRIEF.md
# Up/Down Binary/Decade Digit Counter

A synchronous counter built from 4-bit digit stages that all share one clock. At run time, one input picks the counting direction and another picks the modulus. In binary mode each digit covers 0 to 15. In decade mode each digit covers 0 to 9, as a BCD digit. An active-high load input forces every digit to the value on its data inputs straight away, with no clock needed. Load has priority over every other input.

Each digit has an active-low terminal-count flag. The flag is decoded from the digit's value, the direction and the mode, and it is qualified by that digit's own enable. The flag of each digit drives the enable of the next more significant digit, so the stages together form one wide binary or BCD counter. The flag of the top digit comes out as the chain's ripple terminal count. The parameter `NUM_DIGITS` sets the number of digits.

Top module: `updown_digit_counter`

## Requirements
- R1: While `loadIn` is high, `count` equals `loadData` at once, with no clock edge needed, whatever the other inputs are.
- R2: When `cntEnN` is high and `loadIn` is low, a rising clock edge leaves `count` unchanged.
- R3: With `binDec`=1 and `upDn`=1, each enabled edge adds one to the whole chain, taken as a NUM_DIGITS*4-bit binary value. 15 in a digit wraps to 0.
- R4: With `binDec`=1 and `upDn`=0, each enabled edge subtracts one. 0 in a digit wraps to 15.
- R5: With `binDec`=0 and `upDn`=1, a digit steps up by one, and 9 goes to 0.
- R6: With `binDec`=0 and `upDn`=0, a digit steps down by one, and 0 goes to 9.
- R7: In decade up mode, a digit holding a value from 10 to 15 goes to 0 on its next enabled edge.
- R8: In decade down mode, a digit holding a value from 10 to 15 steps down by one each enabled edge. For example, 12 goes to 11.
- R9: A digit's terminal count is low only when its enable is low and one of these holds: in binary up mode all four bits are 1; in decade up mode bit 0 and bit 3 are both 1 (so 9, 11, 13 and 15 qualify); in either down mode all bits are 0.
- R10: When a digit's enable is high, its terminal count is high.
- R11: Digit k (bits 4k+3..4k, where digit 0 is least significant) steps only on edges where every lower digit is at its terminal value and `cntEnN` is low. For example, 09 goes to 10 counting up in decade mode, and 10 goes to 09 counting down.
- R12: After `loadIn` falls, `count` keeps the loaded value until the first edge that has `cntEnN` low. `loadData` must stay stable while `loadIn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| cntEnN | input | 1 | Active-low count enable of digit 0 |
| upDn | input | 1 | 1 = count up, 0 = count down |
| binDec | input | 1 | 1 = binary digits, 0 = decade digits |
| loadIn | input | 1 | Active-high asynchronous parallel load |
| loadData | input | NUM_DIGITS*4 | Load value, digit 0 in bits 3..0 |
| count | output | NUM_DIGITS*4 | Counter value, digit 0 in bits 3..0 |
| tcN | output | 1 | Active-low ripple terminal count of the top digit |

## Verification
The bench checks the wrap at each end in every mode. A design that got a wrap wrong would show a wrong digit value, for example 10 instead of 0 after 9, or 15 instead of 9 in decade mode. It loads out-of-range decade values: a design that saturated or treated them as 9 would show the wrong result on the next edge. It checks the terminal-count decode in decade up mode on the value 11, which a full-equality decode would miss, and it checks that an enable held high keeps the flag high. It steps a two-digit chain across a digit boundary in both directions, where wrong chaining either moves the upper digit too often or never moves it.

// File: rtl/updn_pkg.sv
package updn_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] BIN_MAX = DIGIT_W'((1 << DIGIT_W) - 1);
  localparam logic [DIGIT_W-1:0] DEC_MAX = DIGIT_W'(9);

  typedef struct packed {
    logic step;
    logic up;
    logic decade;
  } stepCtl_t;
endpackage

// File: rtl/digit_ctrl.sv
module digit_ctrl
  import updn_pkg::*;
(
  input  logic               clk,
  input  logic               ceN,
  input  logic               upDn,
  input  logic               binDec,
  input  logic               loadIn,
  input  logic [DIGIT_W-1:0] count,
  output stepCtl_t           ctl,
  output logic               tcN
);
  logic atTop, atBottom, atTerm;

  always_comb begin
    atTop    = binDec ? (&count) : (count[0] & count[DIGIT_W-1]);
    atBottom = (count == '0);
    atTerm   = upDn ? atTop : atBottom;
    tcN      = ~(~ceN & atTerm);
    ctl.step   = ~ceN & ~loadIn;
    ctl.up     = upDn;
    ctl.decade = ~binDec;
  end

  // R10
  tc_idle_high_chk: assert property (@(posedge clk) ceN |-> tcN);

  // R9
  tc_bin_up_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!ceN && upDn && binDec && count == BIN_MAX) |-> !tcN);

  // R9
  tc_down_zero_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!ceN && !upDn && count == '0) |-> !tcN);
endmodule

// File: rtl/digit_path.sv
module digit_path
  import updn_pkg::*;
(
  input  logic               clk,
  input  logic               loadIn,
  input  logic [DIGIT_W-1:0] loadData,
  input  stepCtl_t           ctl,
  output logic [DIGIT_W-1:0] count
);
  logic [DIGIT_W-1:0] regQ, nxt, topVal;

  always_comb begin
    topVal = ctl.decade ? DEC_MAX : BIN_MAX;
    if (ctl.up)
      nxt = (ctl.decade && regQ >= DEC_MAX) ? '0 : regQ + 1'b1;
    else
      nxt = (regQ == '0) ? topVal : regQ - 1'b1;
  end

  always_ff @(posedge clk or posedge loadIn) begin
    if (loadIn)        regQ <= loadData;
    else if (ctl.step) regQ <= nxt;
  end

  assign count = loadIn ? loadData : regQ;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!$past(loadIn) && !$past(ctl.step)) |-> $stable(count));

  // R5
  dec_up_wrap_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!$past(loadIn) && $past(ctl.step) && $past(ctl.up) && $past(ctl.decade)
     && $past(count) >= DEC_MAX) |-> (count == '0));

  // R4
  bin_down_wrap_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!$past(loadIn) && $past(ctl.step) && !$past(ctl.up) && !$past(ctl.decade)
     && $past(count) == '0) |-> (count == BIN_MAX));
endmodule

// File: rtl/digit_stage.sv
module digit_stage
  import updn_pkg::*;
(
  input  logic               clk,
  input  logic               ceN,
  input  logic               upDn,
  input  logic               binDec,
  input  logic               loadIn,
  input  logic [DIGIT_W-1:0] loadData,
  output logic [DIGIT_W-1:0] count,
  output logic               tcN
);
  stepCtl_t ctl;

  digit_ctrl u_ctrl (
    .clk(clk), .ceN(ceN), .upDn(upDn), .binDec(binDec),
    .loadIn(loadIn), .count(count), .ctl(ctl), .tcN(tcN)
  );

  digit_path u_path (
    .clk(clk), .loadIn(loadIn), .loadData(loadData),
    .ctl(ctl), .count(count)
  );
endmodule

// File: rtl/updown_digit_counter.sv
module updown_digit_counter
  import updn_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int TOTAL_W = NUM_DIGITS * DIGIT_W
) (
  input  logic               clk,
  input  logic               cntEnN,
  input  logic               upDn,
  input  logic               binDec,
  input  logic               loadIn,
  input  logic [TOTAL_W-1:0] loadData,
  output logic [TOTAL_W-1:0] count,
  output logic               tcN
);
  logic [NUM_DIGITS:0] enChain;

  assign enChain[0] = cntEnN;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    digit_stage u_stage (
      .clk(clk), .ceN(enChain[i]), .upDn(upDn), .binDec(binDec),
      .loadIn(loadIn),
      .loadData(loadData[i*DIGIT_W +: DIGIT_W]),
      .count(count[i*DIGIT_W +: DIGIT_W]),
      .tcN(enChain[i+1])
    );
  end

  assign tcN = enChain[NUM_DIGITS];

  // R11
  upper_hold_chk: assert property (@(posedge clk) disable iff (loadIn)
    (!$past(loadIn) && $past(enChain[1])) |->
      $stable(count[TOTAL_W-1:DIGIT_W]));
endmodule

// File: tb/updown_digit_counter_tb.sv
module updown_digit_counter_tb;
  logic clk = 1'b0;
  logic cntEnN = 1'b1, upDn = 1'b1, binDec = 1'b1, loadIn = 1'b1;
  logic [7:0] loadData = 8'h00;
  logic [7:0] count;
  logic tcN;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  updown_digit_counter #(.NUM_DIGITS(2)) u_dut (
    .clk(clk), .cntEnN(cntEnN), .upDn(upDn), .binDec(binDec),
    .loadIn(loadIn), .loadData(loadData), .count(count), .tcN(tcN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Load v; check immediate follow (R1) and retention (R12).
  task automatic doLoad(input logic [7:0] v);
    @(negedge clk);
    cntEnN = 1'b1;
    loadData = v;
    loadIn = 1'b1;
    #2 chk("R1", count, v);
    @(negedge clk);
    loadIn = 1'b0;
    @(negedge clk);
    chk("R12", count, v);
  endtask

  task automatic stepOnce();
    @(negedge clk);
    cntEnN = 1'b0;
    @(negedge clk);
    cntEnN = 1'b1;
  endtask

  task automatic setMode(input logic bin, input logic up);
    @(negedge clk);
    binDec = bin;
    upDn = up;
  endtask

  task automatic testReset();
    @(negedge clk);
    loadIn = 1'b0;
    #1 chk("R1", count, 8'h00);
    chk("R10", tcN, 1);
  endtask

  task automatic testHold();
    setMode(1, 1);
    doLoad(8'h37);
    repeat (3) @(negedge clk);
    chk("R2", count, 8'h37);
  endtask

  task automatic testBinUp();
    setMode(1, 1);
    doLoad(8'h0E);
    stepOnce(); chk("R3", count, 8'h0F);
    stepOnce(); chk("R3", count, 8'h10);
    doLoad(8'hFF);
    cntEnN = 1'b0; #1 chk("R9", tcN, 0);
    cntEnN = 1'b1; #1 chk("R10", tcN, 1);
    stepOnce(); chk("R3", count, 8'h00);
  endtask

  task automatic testBinDown();
    setMode(1, 0);
    doLoad(8'h00);
    cntEnN = 1'b0; #1 chk("R9", tcN, 0);
    cntEnN = 1'b1;
    stepOnce(); chk("R4", count, 8'hFF);
    stepOnce(); chk("R4", count, 8'hFE);
  endtask

  task automatic testDecUp();
    setMode(0, 1);
    doLoad(8'h99);
    cntEnN = 1'b0; #1 chk("R9", tcN, 0);
    cntEnN = 1'b1;
    stepOnce(); chk("R5", count, 8'h00);
    doLoad(8'h09);
    stepOnce(); chk("R11", count, 8'h10);
    doLoad(8'h0C);
    stepOnce(); chk("R7", count, 8'h00);
    // decade up decode on bit0 and bit3: 11 in both digits is terminal
    doLoad(8'hBB);
    cntEnN = 1'b0; #1 chk("R9", tcN, 0);
    cntEnN = 1'b1;
    doLoad(8'h98);
    cntEnN = 1'b0; #1 chk("R9", tcN, 1);
    cntEnN = 1'b1;
  endtask

  task automatic testDecDown();
    setMode(0, 0);
    doLoad(8'h00);
    stepOnce(); chk("R6", count, 8'h99);
    doLoad(8'h10);
    stepOnce(); chk("R11", count, 8'h09);
    doLoad(8'h0C);
    stepOnce(); chk("R8", count, 8'h0B);
    stepOnce(); chk("R8", count, 8'h0A);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testHold();
    testBinUp();
    testBinDown();
    testDecUp();
    testDecDown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule